// File: doc/BRIEF.md
# PWM Request Quantizer

This block takes a PWM request expressed in nanoseconds, a period and a high time, together with the frequency of the generator's input clock. It produces the two load values that a dual-timer PWM generator needs. The generator counts a period of load + 2 clock cycles and holds its output high for duty load + 2 cycles. The quantizer always rounds down. When the requested period is longer than the generator can count, it clamps the period to the longest one and scales the high time so that the duty ratio is kept. It then rewrites the settings the generator cannot produce. A period shorter than two cycles is reported as a range error, and the previous load values are kept.

A one-cycle `req` pulse starts a conversion. The nanosecond-to-cycle conversions run on a shared restoring shift-subtract divider, one quotient bit per clock. A request therefore takes about two dividend widths of cycles, and `done` pulses once when it finishes. The state machine has four states. ST_IDLE moves to ST_DIV_PER when a request is accepted. ST_DIV_PER moves to ST_FINISH on a range error, and otherwise to ST_DIV_DUTY, where the duty division starts. ST_DIV_DUTY moves to ST_FINISH when its quotient is ready. ST_FINISH always returns to ST_IDLE and drives the outputs. A typical input clock is 100 MHz, which gives 10 ns per cycle.

Top module: `pwm_req_quantizer`

## Requirements
- R1: Period cycles PC = floor(period_ns × clk_rate_hz / 10^9), and when no range error occurs period_load = PC − 2.
- R2: A requested duty larger than the requested period is replaced by the requested period before any other step.
- R3: Without clamping, duty cycles DC = floor(duty_ns × clk_rate_hz / 10^9), and duty_load = DC − 2 once R6 and R7 have been applied.
- R4: If PC < 2, range_err is 1 with the done pulse and period_load and duty_load keep their previous values.
- R5: If PC exceeds 2^32 + 1, PC becomes 2^32 + 1, so period_load = 0xFFFFFFFF, and DC = floor(duty_ns × (2^32 + 1) / period_ns).
- R6: If DC ≥ PC, DC becomes PC − 1, because 100% high time cannot be produced.
- R7: If DC < 2 after R6, DC becomes PC, so duty_load equals period_load and the output is 0%.
- R8: Each accepted request gives exactly one done pulse of one cycle. range_err is valid in that cycle and holds until the next done.
- R9: A req pulse that arrives while a conversion is in progress is ignored. It produces no extra done and does not change the result.
- R10: After reset, period_load and duty_load are 0, and done and range_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start pulse, accepted only when idle |
| period_ns | input | 64 | Requested period in ns |
| duty_ns | input | 64 | Requested high time in ns |
| clk_rate_hz | input | 32 | Generator input clock frequency in Hz |
| period_load | output | 32 | Period load value (cycles − 2) |
| duty_load | output | 32 | High-time load value (cycles − 2) |
| done | output | 1 | One-cycle completion pulse |
| range_err | output | 1 | Last request had fewer than two period cycles |

## Verification
The bench sweeps periods and duties at 1 GHz, 100 MHz and an odd rate, so that every small cycle count is reached. A design that skipped the 100%-to-PC−1 remap would make duty_load equal period_load and give a 0% output. A design that left a one-cycle high time in place would emit duty_load 0xFFFFFFFF. Clamp requests on both sides of 2^32 + 1 cycles would expose a design that clamped the duty on its own instead of scaling it, because the duty ratio would grow. Range-error requests check that the loads stay unchanged. A request sent while the block is busy would show a block that restarted, with a second done or the wrong result.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DIV_PER,
        ST_DIV_DUTY,
        ST_FINISH
    } pwmq_state_e;
endpackage

// File: rtl/pwmq_divider.sv
module pwmq_divider #(
    parameter int DVD_W = 97,
    parameter int DSR_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DSR_W-1:0] divisor,
    output logic [DVD_W-1:0] quotient,
    output logic             fin
);
    localparam int CNT_W = $clog2(DVD_W + 1);

    logic [DVD_W-1:0] work_q;
    logic [DSR_W:0]   rem_q;
    logic [DSR_W-1:0] dsr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    logic [DSR_W:0]   rem_sh;
    logic             ge;
    logic [DSR_W:0]   rem_nxt;

    always_comb begin
        rem_sh  = {rem_q[DSR_W-1:0], work_q[DVD_W-1]};
        ge      = (rem_sh >= {1'b0, dsr_q});
        rem_nxt = ge ? (rem_sh - {1'b0, dsr_q}) : rem_sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_q <= '0;
            rem_q  <= '0;
            dsr_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (start && !run_q) begin
                work_q <= dividend;
                rem_q  <= '0;
                dsr_q  <= divisor;
                cnt_q  <= CNT_W'(DVD_W - 1);
                run_q  <= 1'b1;
            end else if (run_q) begin
                work_q <= {work_q[DVD_W-2:0], ge};
                rem_q  <= rem_nxt;
                if (cnt_q == '0) begin
                    run_q <= 1'b0;
                    fin   <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign quotient = work_q;

    // The remainder left at the end must be below the divisor (R1).
    assert_rem_below_divisor_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (rem_q < {1'b0, dsr_q}));

    // The controller never restarts a running division (R9).
    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> !start);
endmodule

// File: rtl/pwmq_fixup.sv
module pwmq_fixup #(
    parameter int CYC_W  = 33,
    parameter int LOAD_W = 32
) (
    input  logic [CYC_W-1:0]  pc,
    input  logic [CYC_W-1:0]  dc_raw,
    output logic [LOAD_W-1:0] per_load,
    output logic [LOAD_W-1:0] duty_load
);
    localparam logic [CYC_W-1:0] ONE = CYC_W'(1);
    localparam logic [CYC_W-1:0] TWO = CYC_W'(2);

    logic [CYC_W-1:0] dc_cap;
    logic [CYC_W-1:0] dc_fin;
    logic [CYC_W-1:0] pc_m2;
    logic [CYC_W-1:0] dc_m2;

    always_comb begin
        // a full-period high time is not possible: drop one cycle
        dc_cap = (dc_raw >= pc) ? (pc - ONE) : dc_raw;
        // a high time under two cycles is not possible: emit 0%
        dc_fin = (dc_cap < TWO) ? pc : dc_cap;
        pc_m2  = pc - TWO;
        dc_m2  = dc_fin - TWO;
        per_load  = pc_m2[LOAD_W-1:0];
        duty_load = dc_m2[LOAD_W-1:0];
    end
endmodule

// File: rtl/pwm_req_quantizer.sv
module pwm_req_quantizer #(
    parameter int NS_W       = 64,
    parameter int RATE_W     = 32,
    parameter int LOAD_W     = 32,
    parameter int NS_PER_SEC = 1_000_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [NS_W-1:0]   period_ns,
    input  logic [NS_W-1:0]   duty_ns,
    input  logic [RATE_W-1:0] clk_rate_hz,
    output logic [LOAD_W-1:0] period_load,
    output logic [LOAD_W-1:0] duty_load,
    output logic              done,
    output logic              range_err
);
    import pwmq_pkg::*;

    localparam int CYC_W  = LOAD_W + 1;
    localparam int MUL_W  = (RATE_W > CYC_W) ? RATE_W : CYC_W;
    localparam int PROD_W = NS_W + MUL_W;
    localparam logic [PROD_W-1:0] CYC_MAX = (PROD_W'(1) << LOAD_W) + PROD_W'(1);
    localparam logic [PROD_W-1:0] CYC_MIN = PROD_W'(2);

    pwmq_state_e state_q, state_d;

    logic [NS_W-1:0]   per_q;
    logic [NS_W-1:0]   duty_q;
    logic [RATE_W-1:0] rate_q;
    logic [CYC_W-1:0]  pc_q;
    logic [CYC_W-1:0]  dc_q;
    logic              err_q;

    logic [NS_W-1:0]   duty_lim;
    logic              div_go;
    logic [PROD_W-1:0] div_dvd;
    logic [NS_W-1:0]   div_dsr;
    logic [PROD_W-1:0] div_quo;
    logic              div_fin;
    logic              quo_small;
    logic              quo_big;
    logic [LOAD_W-1:0] fix_per;
    logic [LOAD_W-1:0] fix_duty;

    assign duty_lim  = (duty_ns > period_ns) ? period_ns : duty_ns;
    assign quo_small = (div_quo < CYC_MIN);
    assign quo_big   = (div_quo > CYC_MAX);

    pwmq_divider #(.DVD_W(PROD_W), .DSR_W(NS_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_go),
        .dividend (div_dvd),
        .divisor  (div_dsr),
        .quotient (div_quo),
        .fin      (div_fin)
    );

    pwmq_fixup #(.CYC_W(CYC_W), .LOAD_W(LOAD_W)) u_fix (
        .pc        (pc_q),
        .dc_raw    (dc_q),
        .per_load  (fix_per),
        .duty_load (fix_duty)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and divider launch
    always_comb begin
        state_d = state_q;
        div_go  = 1'b0;
        div_dvd = '0;
        div_dsr = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    state_d = ST_DIV_PER;
                    div_go  = 1'b1;
                    div_dvd = PROD_W'(period_ns) * PROD_W'(clk_rate_hz);
                    div_dsr = NS_W'(NS_PER_SEC);
                end
            end
            ST_DIV_PER: begin
                if (div_fin) begin
                    if (quo_small) begin
                        state_d = ST_FINISH;
                    end else begin
                        state_d = ST_DIV_DUTY;
                        div_go  = 1'b1;
                        if (quo_big) begin
                            div_dvd = PROD_W'(duty_q) * CYC_MAX;
                            div_dsr = per_q;
                        end else begin
                            div_dvd = PROD_W'(duty_q) * PROD_W'(rate_q);
                            div_dsr = NS_W'(NS_PER_SEC);
                        end
                    end
                end
            end
            ST_DIV_DUTY: begin
                if (div_fin) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q       <= '0;
            duty_q      <= '0;
            rate_q      <= '0;
            pc_q        <= '0;
            dc_q        <= '0;
            err_q       <= 1'b0;
            period_load <= '0;
            duty_load   <= '0;
            done        <= 1'b0;
            range_err   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        per_q  <= period_ns;
                        duty_q <= duty_lim;
                        rate_q <= clk_rate_hz;
                    end
                end
                ST_DIV_PER: begin
                    if (div_fin) begin
                        err_q <= quo_small;
                        pc_q  <= quo_big ? CYC_MAX[CYC_W-1:0] : div_quo[CYC_W-1:0];
                    end
                end
                ST_DIV_DUTY: begin
                    if (div_fin) dc_q <= div_quo[CYC_W-1:0];
                end
                ST_FINISH: begin
                    done      <= 1'b1;
                    range_err <= err_q;
                    if (!err_q) begin
                        period_load <= fix_per;
                        duty_load   <= fix_duty;
                    end
                end
            endcase
        end
    end

    // done is a single-cycle pulse (R8)
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // a range error leaves both load values as they were (R4)
    assert_err_keeps_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && range_err) |-> ($stable(period_load) && $stable(duty_load)));

    // a produced high time never exceeds its period (R6)
    assert_duty_within_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !range_err) |-> (duty_load <= period_load));

    // a clamped duty division is only started with a nonzero divisor (R5)
    assert_clamp_divisor_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        div_go |-> (div_dsr != '0));
endmodule

// File: tb/pwm_req_quantizer_tb.sv
module pwm_req_quantizer_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [127:0] CMAX = (128'd1 << 32) + 128'd1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [63:0] period_ns = '0;
    logic [63:0] duty_ns = '0;
    logic [31:0] clk_rate_hz = '0;
    logic [31:0] period_load;
    logic [31:0] duty_load;
    logic        done;
    logic        range_err;

    int checks = 0;
    int fails = 0;
    logic [31:0] exp_pl = '0;
    logic [31:0] exp_dl = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_req_quantizer u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .period_ns(period_ns),
        .duty_ns(duty_ns), .clk_rate_hz(clk_rate_hz), .period_load(period_load),
        .duty_load(duty_load), .done(done), .range_err(range_err)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (done) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic run(input logic [63:0] p, input logic [63:0] d, input logic [31:0] r);
        logic [127:0] dd, pc, dc;
        bit e_err, clamp, seen;
        string tag;
        dd = (d > p) ? {64'd0, p} : {64'd0, d};
        pc = ({64'd0, p} * r) / 128'd1000000000;
        e_err = (pc < 2);
        clamp = (pc > CMAX);
        if (clamp) begin
            pc = CMAX;
            dc = (dd * CMAX) / {64'd0, p};
        end else begin
            dc = (dd * r) / 128'd1000000000;
        end
        if (e_err) tag = "R4";
        else if (clamp) tag = "R5";
        else tag = (d > p) ? "R2 R1 R3" : "R1 R3";
        if (!e_err) begin
            if (dc >= pc) begin dc = pc - 1; tag = {tag, " R6"}; end
            if (dc < 2) begin dc = pc; tag = {tag, " R7"}; end
            exp_pl = 32'(pc - 2);
            exp_dl = 32'(dc - 2);
        end
        period_ns = p; duty_ns = d; clk_rate_hz = r;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        wait_done(seen);
        check(seen, "R8", "done seen", 64'(seen), 64'd1);
        check(range_err == e_err, tag, "range_err", 64'(range_err), 64'(e_err));
        check(period_load == exp_pl, tag, "period_load", 64'(period_load), 64'(exp_pl));
        check(duty_load == exp_dl, tag, "duty_load", 64'(duty_load), 64'(exp_dl));
        @(negedge clk);
        check(!done, "R8", "done one cycle", 64'(done), 64'd0);
        check(range_err == e_err, "R8", "range_err held", 64'(range_err), 64'(e_err));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        bit seen;
        int extra;
        repeat (3) @(negedge clk);
        check(period_load == 0 && duty_load == 0, "R10", "reset loads",
              64'(period_load), 64'd0);
        check(!done && !range_err, "R10", "reset flags", 64'({done, range_err}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // 1 GHz: one ns per cycle, every small count including d > p
        for (int p = 0; p <= 9; p++)
            for (int d = 0; d <= p + 2; d++)
                run(64'(p), 64'(d), 32'd1000000000);
        // 100 MHz sweep
        for (int p = 0; p <= 60; p += 3)
            for (int d = 0; d <= p; d += 5)
                run(64'(p), 64'(d), 32'd100000000);
        // odd rate
        for (int p = 50; p <= 140; p += 30)
            for (int d = 0; d <= p; d += 13)
                run(64'(p), 64'(d), 32'd33333333);

        // clamp boundaries R5
        run(64'(CMAX), 64'(CMAX), 32'd1000000000);
        run(64'(CMAX) + 64'd1, 64'd3, 32'd1000000000);
        run(64'h8000_0000_0000_0000, 64'h4000_0000_0000_0000, 32'd100000000);
        run(64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_5555_5555_5555, 32'hFFFF_FFFF);
        run(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF);
        // error after a valid result keeps the loads (R4)
        run(64'd1000, 64'd300, 32'd100000000);
        run(64'd15, 64'd5, 32'd100000000);

        // R9: second request while busy is ignored
        period_ns = 64'd1000; duty_ns = 64'd300; clk_rate_hz = 32'd100000000;
        req = 1'b1; @(negedge clk); req = 1'b0;
        repeat (5) @(negedge clk);
        period_ns = 64'd500; duty_ns = 64'd100;
        req = 1'b1; @(negedge clk); req = 1'b0;
        wait_done(seen);
        check(seen, "R9", "busy done", 64'(seen), 64'd1);
        check(period_load == 32'd98, "R9", "busy period_load", 64'(period_load), 64'd98);
        check(duty_load == 32'd28, "R9", "busy duty_load", 64'(duty_load), 64'd28);
        extra = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        check(extra == 0, "R9", "no extra done", 64'(extra), 64'd0);

        summary();
        $finish;
    end
endmodule